// File: doc/BRIEF.md
# BCD Calendar Clock with Digital Trim

The block keeps wall-clock time and a calendar in packed BCD: seconds, minutes, 24-hour hours, a day-of-week counter, date, month and a two-digit year covering 2000 to 2099. A clock-enable pulse at the nominal 32.768 kHz rate drives a prescaler. When the prescaler wraps, it advances a free-running timekeeping core by one second. Software never touches the core directly. It works through a set of holding registers, with two control bits that move time between the two sides. One bit freezes a snapshot of the core for reading. The other opens the holding registers for writing and commits them to the core when it closes.

Crystal error is trimmed digitally. A signed 5-bit value lengthens or shortens one second in every calibration window by that many prescaler counts. This removes or adds input pulses. For measuring the crystal, a calibration mode replaces the power-fail comparator signal on the shared output with a square wave of 1/512 of the prescaler period, which is 512 Hz at nominal rate.

Register map, as seen from the synchronous port: address 0 is control, address 1 is the trim value, and addresses 2 to 8 are the holding registers. The holding registers are, in order, seconds, minutes, hours, day of week, date, month and year. All other addresses read as zero.

Top module: `rtc_calendar`

## Requirements
- R1: Seconds and minutes count 00 to 59 and hours count 00 to 23 in BCD. Each wrap carries into the next field. With no trim active, one second passes every PRESCALE enabled ticks.
- R2: At midnight the day of week steps 1 to 7 and wraps back to 1. The date wraps after the last day of the month: 30 for months 04, 06, 09 and 11, 29 for February when the year is divisible by 4, 28 for other Februaries, and 31 otherwise. Month 12 wraps to 01, and year 99 wraps to 00.
- R3: A 0-to-1 change of control bit 0 copies the core into the holding registers when control bit 1 is 0 both before and after the write. If a second completes in that same cycle, the copy holds the advanced time. The holding registers then stay unchanged while bit 0 remains 1.
- R4: While control bit 1 is 1, writes to addresses 2 to 8 set the holding bytes. Clearing bit 1 loads the core from the holding registers and restarts the prescaler, so the next second lands exactly PRESCALE ticks later.
- R5: Writes to addresses 2 to 8 while control bit 1 is 0 leave the holding registers unchanged.
- R6: The core keeps counting while a snapshot is frozen. A later snapshot shows the elapsed seconds.
- R7: Address 1 holds the trim magnitude in bits 4:0 and the sign in bit 5. The first second of each CAL_WINDOW-second window lasts PRESCALE minus the magnitude ticks when the sign is 1 (pulses added), and PRESCALE plus the magnitude ticks when the sign is 0 (pulses removed). The other seconds last PRESCALE ticks. The window restarts on a core load.
- R8: With control bit 2 set, cal_out is a square wave of period PRESCALE/512 ticks. It is low in the first half of that period after a prescaler restart. With bit 2 clear, cal_out follows pfail_in.
- R9: After reset the core and the holding registers read 00:00:00, day 1, date 01, month 01, year 00. Control and trim are zero.
- R10: reg_rdata shows the addressed register one clock after the address is presented. Address 0 reads control bits 2:0, address 1 reads trim bits 5:0, and unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle enable per 32.768 kHz input pulse |
| pfail_in | input | 1 | Power-fail comparator result, passed through outside calibration mode |
| reg_addr | input | AW | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| cal_out | output | 1 | Calibration square wave or comparator pass-through |

## Verification
The checker watches every cycle for the following: the core holds still unless a second completes or a load occurs, and a completed second always moves it. A snapshot equals the core on the cycle after capture, and a frozen or closed holding set never changes. A commit transfers the holding registers into the core exactly. Calendar carries across month ends, leap Februaries and the century wrap, the exact tick counts of trimmed seconds, the pending-update capture and the square-wave phase are shown only by the bench's directed scenarios, which count enabled ticks precisely.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   // Packed time; seconds occupy the low byte so byte i maps to address 2+i.
   typedef struct packed {
      logic [7:0] yr;
      logic [7:0] mon;
      logic [7:0] date;
      logic [7:0] dow;
      logic [7:0] hr;
      logic [7:0] min;
      logic [7:0] sec;
   } rtc_time_t;

   localparam int TIME_BYTES = 7;
   localparam int FIRST_TIME_ADDR = 2;

   localparam rtc_time_t TIME_RST = '{yr: 8'h00, mon: 8'h01, date: 8'h01,
                                      dow: 8'h01, hr: 8'h00, min: 8'h00,
                                      sec: 8'h00};

   // BCD increment with wrap from hi (or anything above) back to lo.
   function automatic logic [7:0] bcd_step(logic [7:0] v, logic [7:0] lo,
                                           logic [7:0] hi);
      if (v >= hi)
         return lo;
      else if (v[3:0] >= 4'd9)
         return {v[7:4] + 4'd1, 4'd0};
      else
         return v + 8'd1;
   endfunction

   // 10*t mod 4 equals 2 when t is odd, so the ones digit decides.
   function automatic logic is_leap(logic [7:0] yr);
      if (yr[4])
         return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
      else
         return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
   endfunction

   function automatic logic [7:0] month_last(logic [7:0] mon, logic [7:0] yr);
      case (mon)
         8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
   parameter int PRESCALE   = 32768,
   parameter int CAL_WINDOW = 60,
   parameter int MAG_W      = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             restart,
   input  logic             cal_sign,
   input  logic [MAG_W-1:0] cal_mag,
   output logic             sec_tick,
   output logic             wave
);
   localparam int CW = $clog2(PRESCALE + (1 << MAG_W));
   localparam int WB = $clog2(PRESCALE / 512) - 1;
   localparam logic [CW-1:0] BASE = CW'(PRESCALE - 1);

   if (PRESCALE < 1024 || (PRESCALE & (PRESCALE - 1)) != 0) begin : g_bad_presc
      $error("PRESCALE must be a power of two of at least 1024");
   end
   if (CAL_WINDOW < 1) begin : g_bad_window
      $error("CAL_WINDOW must be at least one second");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] term;
   logic          adj;
   logic          wrap;

   // Window position: a single-second window trims every second.
   if (CAL_WINDOW == 1) begin : g_win_every
      assign adj = 1'b1;
   end else begin : g_win_count
      localparam int WW = $clog2(CAL_WINDOW);
      logic [WW-1:0] win;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            win <= '0;
         else if (restart)
            win <= '0;
         else if (wrap)
            win <= (win == WW'(CAL_WINDOW - 1)) ? '0 : win + 1'b1;
      end
      assign adj = (win == '0);
   end

   always_comb begin
      if (!adj)
         term = BASE;
      else if (cal_sign)
         term = BASE - CW'(cal_mag);
      else
         term = BASE + CW'(cal_mag);
   end

   assign wrap     = tick_en && (cnt == term);
   assign sec_tick = wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart)
         cnt <= '0;
      else if (tick_en)
         cnt <= wrap ? '0 : cnt + 1'b1;
   end

   assign wave = cnt[WB];

endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
   import rtc_cal_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sec_tick,
   input  logic      load,
   input  rtc_time_t load_val,
   output rtc_time_t now,
   output rtc_time_t nxt
);
   logic [7:0] last_day;

   assign last_day = month_last(now.mon, now.yr);

   always_comb begin
      nxt = now;
      if (load) begin
         nxt = load_val;
      end else if (sec_tick) begin
         nxt.sec = bcd_step(now.sec, 8'h00, 8'h59);
         if (now.sec >= 8'h59) begin
            nxt.min = bcd_step(now.min, 8'h00, 8'h59);
            if (now.min >= 8'h59) begin
               nxt.hr = bcd_step(now.hr, 8'h00, 8'h23);
               if (now.hr >= 8'h23) begin
                  nxt.dow  = bcd_step(now.dow, 8'h01, 8'h07);
                  nxt.date = bcd_step(now.date, 8'h01, last_day);
                  if (now.date >= last_day) begin
                     nxt.mon = bcd_step(now.mon, 8'h01, 8'h12);
                     if (now.mon >= 8'h12)
                        nxt.yr = bcd_step(now.yr, 8'h00, 8'h99);
                  end
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         now <= TIME_RST;
      else
         now <= nxt;
   end

endmodule

// File: rtl/rtc_user_regs.sv
module rtc_user_regs
   import rtc_cal_pkg::*;
#(
   parameter int AW    = 4,
   parameter int MAG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr,
   input  logic             we,
   input  logic [7:0]       wdata,
   input  rtc_time_t        core_nxt,
   output logic [7:0]       rdata,
   output rtc_time_t        hold,
   output logic             load,
   output logic             capture,
   output logic             rd_q,
   output logic             wr_q,
   output logic             cal_en,
   output logic             cal_sign,
   output logic [MAG_W-1:0] cal_mag
);
   localparam logic [AW-1:0] A_CTRL = AW'(0);
   localparam logic [AW-1:0] A_TRIM = AW'(1);

   logic ctl_wr;
   logic rd_new;
   logic wr_new;
   logic [7:0] rd_mux;

   assign ctl_wr  = we && (addr == A_CTRL);
   assign rd_new  = ctl_wr ? wdata[0] : rd_q;
   assign wr_new  = ctl_wr ? wdata[1] : wr_q;
   assign capture = rd_new && !rd_q && !wr_q && !wr_new;
   assign load    = wr_q && !wr_new;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q     <= 1'b0;
         wr_q     <= 1'b0;
         cal_en   <= 1'b0;
         cal_sign <= 1'b0;
         cal_mag  <= '0;
      end else begin
         rd_q <= rd_new;
         wr_q <= wr_new;
         if (ctl_wr)
            cal_en <= wdata[2];
         if (we && addr == A_TRIM) begin
            cal_mag  <= wdata[MAG_W-1:0];
            cal_sign <= wdata[MAG_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold <= TIME_RST;
      end else if (capture) begin
         hold <= core_nxt;
      end else if (we && wr_q) begin
         for (int i = 0; i < TIME_BYTES; i++) begin
            if (addr == AW'(FIRST_TIME_ADDR + i))
               hold[8*i +: 8] <= wdata;
         end
      end
   end

   always_comb begin
      rd_mux = 8'h00;
      if (addr == A_CTRL)
         rd_mux = {5'b0, cal_en, wr_q, rd_q};
      else if (addr == A_TRIM)
         rd_mux = {{(7 - MAG_W){1'b0}}, cal_sign, cal_mag};
      for (int i = 0; i < TIME_BYTES; i++) begin
         if (addr == AW'(FIRST_TIME_ADDR + i))
            rd_mux = hold[8*i +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= 8'h00;
      else
         rdata <= rd_mux;
   end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_cal_pkg::*;
#(
   parameter int PRESCALE   = 32768,
   parameter int CAL_WINDOW = 60,
   parameter int AW         = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_en,
   input  logic          pfail_in,
   input  logic [AW-1:0] reg_addr,
   input  logic          reg_we,
   input  logic [7:0]    reg_wdata,
   output logic [7:0]    reg_rdata,
   output logic          cal_out
);
   localparam int MAG_W = 5;

   if (AW < 4) begin : g_bad_aw
      $error("AW must reach addresses 0 to 8");
   end

   rtc_time_t        core_now;
   rtc_time_t        core_nxt;
   rtc_time_t        hold;
   logic             load;
   logic             capture;
   logic             rd_q;
   logic             wr_q;
   logic             cal_en;
   logic             cal_sign;
   logic [MAG_W-1:0] cal_mag;
   logic             sec_tick;
   logic             wave;

   rtc_prescale #(.PRESCALE(PRESCALE), .CAL_WINDOW(CAL_WINDOW), .MAG_W(MAG_W)) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .restart  (load),
      .cal_sign (cal_sign),
      .cal_mag  (cal_mag),
      .sec_tick (sec_tick),
      .wave     (wave)
   );

   rtc_cal_core u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .sec_tick (sec_tick),
      .load     (load),
      .load_val (hold),
      .now      (core_now),
      .nxt      (core_nxt)
   );

   rtc_user_regs #(.AW(AW), .MAG_W(MAG_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (reg_addr),
      .we       (reg_we),
      .wdata    (reg_wdata),
      .core_nxt (core_nxt),
      .rdata    (reg_rdata),
      .hold     (hold),
      .load     (load),
      .capture  (capture),
      .rd_q     (rd_q),
      .wr_q     (wr_q),
      .cal_en   (cal_en),
      .cal_sign (cal_sign),
      .cal_mag  (cal_mag)
   );

   assign cal_out = cal_en ? wave : pfail_in;

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
   import rtc_cal_pkg::*;
#(
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sec_tick,
   input logic          load,
   input logic          capture,
   input logic          rd_q,
   input logic          wr_q,
   input logic          reg_we,
   input logic [AW-1:0] reg_addr,
   input rtc_time_t     core_now,
   input rtc_time_t     hold
);
   logic time_addr;
   assign time_addr = (reg_addr >= AW'(2)) && (reg_addr <= AW'(8));

   AST_CORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_tick && !load) |=> $stable(core_now)); // R1

   AST_CORE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !load) |=> (core_now != $past(core_now))); // R6

   AST_SNAPSHOT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (hold == core_now)); // R3

   AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_q && !wr_q) |=> $stable(hold)); // R3

   AST_CLOSED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && time_addr && !wr_q) |=> $stable(hold)); // R5

   AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (core_now == $past(hold))); // R4

endmodule

bind rtc_calendar rtc_calendar_chk #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sec_tick (sec_tick),
   .load     (load),
   .capture  (capture),
   .rd_q     (rd_q),
   .wr_q     (wr_q),
   .reg_we   (reg_we),
   .reg_addr (reg_addr),
   .core_now (core_now),
   .hold     (hold)
);

// File: tb/rtc_calendar_test.sv
`timescale 1ns/1ps
module rtc_calendar_test;
   localparam int P  = 1024;
   localparam int WN = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       pfail_in = 1'b0;
   logic [3:0] reg_addr = '0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       cal_out;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 0;
   logic cal_bit = 1'b0;

   always #2.5 clk = ~clk;

   rtc_calendar #(.PRESCALE(P), .CAL_WINDOW(WN), .AW(4)) uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pfail_in(pfail_in),
      .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .cal_out(cal_out)
   );

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_we = 1'b0;
      @(negedge clk);
      d = reg_rdata;
   endtask

   task automatic ticks(int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   // Packed {yr,mon,date,dow,hr,min,sec}
   task automatic set_time(logic [55:0] t);
      wr(4'd0, {5'b0, cal_bit, 2'b10});
      for (int i = 0; i < 7; i++) wr(4'(2 + i), t[8*i +: 8]);
      wr(4'd0, {5'b0, cal_bit, 2'b00});
   endtask

   task automatic snap();
      wr(4'd0, {5'b0, cal_bit, 2'b01});
      wr(4'd0, {5'b0, cal_bit, 2'b00});
   endtask

   task automatic expect_time(string req, logic [55:0] t);
      logic [7:0] d;
      for (int i = 0; i < 7; i++) begin
         rd(4'(2 + i), d);
         check(req, d, t[8*i +: 8]);
      end
   endtask

   task automatic expect_sec(string req, logic [7:0] s);
      logic [7:0] d;
      rd(4'd2, d);
      check(req, d, s);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      expect_time("R9 reset time", {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00});
      rd(4'd0, d); check("R9 ctrl reset", d, 8'h00);
      rd(4'd1, d); check("R9 trim reset", d, 8'h00);
      rd(4'd12, d); check("R10 unused addr", d, 8'h00);
      pfail_in = 1'b1; @(negedge clk);
      check("R9 cal_out passes pfail", {7'b0, cal_out}, 8'h01);
      pfail_in = 1'b0; @(negedge clk);
   endtask

   task automatic t_seconds();
      set_time({8'h21, 8'h06, 8'h15, 8'h03, 8'h12, 8'h34, 8'h58});
      ticks(P - 1); snap(); expect_sec("R4 restart full second", 8'h58);
      ticks(1); snap(); expect_sec("R1 one second", 8'h59);
      ticks(P); snap();
      expect_time("R1 minute carry", {8'h21, 8'h06, 8'h15, 8'h03, 8'h12, 8'h35, 8'h00});
   endtask

   task automatic t_rollovers();
      set_time({8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59});
      ticks(P); snap();
      expect_time("R2 century wrap", {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00});
      set_time({8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59});
      ticks(P); snap();
      expect_time("R2 leap Feb 29", {8'h24, 8'h02, 8'h29, 8'h04, 8'h00, 8'h00, 8'h00});
      ticks(P * 0 + 1); // idle single tick does not finish a second
      set_time({8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59});
      ticks(P); snap();
      expect_time("R2 leap to March", {8'h24, 8'h03, 8'h01, 8'h05, 8'h00, 8'h00, 8'h00});
      set_time({8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59});
      ticks(P); snap();
      expect_time("R2 common Feb", {8'h23, 8'h03, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00});
      set_time({8'h22, 8'h04, 8'h30, 8'h06, 8'h23, 8'h59, 8'h59});
      ticks(P); snap();
      expect_time("R2 30-day month", {8'h22, 8'h05, 8'h01, 8'h07, 8'h00, 8'h00, 8'h00});
   endtask

   task automatic t_pending_capture();
      set_time({8'h20, 8'h01, 8'h01, 8'h01, 8'h10, 8'h00, 8'h00});
      ticks(P - 1);
      @(negedge clk);
      reg_addr = 4'd0; reg_wdata = {5'b0, cal_bit, 2'b01}; reg_we = 1'b1; tick_en = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; tick_en = 1'b0;
      wr(4'd0, {5'b0, cal_bit, 2'b00});
      expect_sec("R3 pending second captured", 8'h01);
   endtask

   task automatic t_freeze();
      logic [7:0] d;
      set_time({8'h20, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00});
      wr(4'd0, {5'b0, cal_bit, 2'b01});
      ticks(2 * P);
      expect_sec("R3 frozen hold", 8'h00);
      wr(4'd2, 8'h45);
      expect_sec("R5 write while frozen ignored", 8'h00);
      wr(4'd0, {5'b0, cal_bit, 2'b00});
      wr(4'd3, 8'h33);
      rd(4'd3, d); check("R5 closed write ignored", d, 8'h00);
      snap();
      expect_sec("R6 core ran during freeze", 8'h02);
   endtask

   task automatic t_trim();
      logic [7:0] d;
      wr(4'd1, 8'h25);
      rd(4'd1, d); check("R10 trim readback", d, 8'h25);
      set_time({8'h20, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00});
      ticks(P - 6); snap(); expect_sec("R7 add pulses before", 8'h00);
      ticks(1); snap(); expect_sec("R7 add pulses short second", 8'h01);
      ticks(P - 1); snap(); expect_sec("R7 untrimmed second before", 8'h01);
      ticks(1); snap(); expect_sec("R7 untrimmed second", 8'h02);
      wr(4'd1, 8'h03);
      set_time({8'h20, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00});
      ticks(P + 2); snap(); expect_sec("R7 remove pulses before", 8'h00);
      ticks(1); snap(); expect_sec("R7 remove pulses long second", 8'h01);
      wr(4'd1, 8'h00);
   endtask

   task automatic t_cal_out();
      logic [7:0] d;
      cal_bit = 1'b1;
      set_time({8'h20, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00});
      rd(4'd0, d); check("R10 ctrl readback", d, 8'h04);
      pfail_in = 1'b1; @(negedge clk);
      check("R8 wave low after restart", {7'b0, cal_out}, 8'h00);
      ticks(1);
      check("R8 wave high half", {7'b0, cal_out}, 8'h01);
      ticks(1);
      check("R8 wave period", {7'b0, cal_out}, 8'h00);
      cal_bit = 1'b0;
      wr(4'd0, 8'h00);
      check("R8 pfail restored high", {7'b0, cal_out}, 8'h01);
      pfail_in = 1'b0; @(negedge clk);
      check("R8 pfail restored low", {7'b0, cal_out}, 8'h00);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_seconds();
      t_rollovers();
      t_pending_capture();
      t_freeze();
      t_trim();
      t_cal_out();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule